// File: doc/BRIEF.md
# Peripheral Interrupt Flag Register Bank

This block gathers interrupt requests from a microcontroller-style peripheral set into three 8-bit flag registers. Peripherals deliver one-cycle strobes: timer overflow or period match, capture/compare events, converter done, serial transfer done, bus collision, memory write done, comparator change, low-voltage detect and clock failover to the internal oscillator. Each strobe latches a sticky flag that stays set until software clears it. Two UART channels instead supply level status for their receive and transmit buffers. Those bits mirror the buffer state, and software cannot write them.

Software reaches the bank through a small register port. It takes a 2-bit register select. Reads return the selected register combinationally, and writes take effect on the next clock edge. A downstream interrupt controller sees all 24 flags at once on a registered flat vector. Bit `8*r + b` of that vector is bit `b` of register `r`. Enable masking and priority belong to the interrupt controller, not to this block.

Top module: `pifr_bank`

## Requirements
- R1: While `rst` is high at a clock edge, all three registers become 0, whatever the event, UART and write inputs are doing.
- R2: A high `evt_pulse[i]` on a sticky position sets `flag_vec[i]` at the next clock edge. No enable of any kind gates this. The non-sticky positions are 4, 5, 13, 20 and 21.
- R3: A sticky flag holds its value until a software write to its register stores 0 in that bit. The write takes effect at the next edge.
- R4: When an event strobe and a software write of 0 hit the same sticky bit in the same cycle, the bit ends up set.
- R5: A software write of 1 to a sticky bit sets it at the next edge.
- R6: The UART receive mirrors sit at flat positions 5 (channel 0) and 21 (channel 1). Each follows `rx_full` of its channel with one cycle of delay, and software writes have no effect on it.
- R7: The UART transmit mirrors sit at flat positions 4 (channel 0) and 20 (channel 1). Each follows `tx_empty` of its channel with one cycle of delay, and software writes have no effect on it.
- R8: Flat position 13 is unimplemented. It is bit 5 of register 1. It always reads 0 and ignores both writes and event strobes.
- R9: The capture/compare flags take no events while their channel's `ccp_pwm` bit is high. Channels 0 to 4 map to flat positions 2, 8, 16, 17 and 18.
- R10: For `sw_addr` 0 to 2, `sw_rdata` shows that register combinationally. Select 3 reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 24 | One-cycle event strobes, bit i aimed at flag i |
| ccp_pwm | input | 5 | Capture/compare channel is in PWM mode |
| rx_full | input | 2 | UART receive buffer holds data, per channel |
| tx_empty | input | 2 | UART transmit buffer is empty, per channel |
| sw_addr | input | 2 | Register select |
| sw_we | input | 1 | Write strobe |
| sw_wdata | input | 8 | Write data |
| sw_rdata | output | 8 | Read data of the selected register |
| flag_vec | output | 24 | All flags, registered, to the interrupt controller |

## Verification
The assertions check several rules on every cycle. Ungated strobes on sticky bits must set their flags, and set sticky bits must survive any cycle without a write to their register. The four UART mirrors must track their inputs one cycle late, and position 13 must stay at zero. PWM-mode channels must not gain flags on their own, and the read port must agree with the flag vector. The bench scenarios are needed for the reset values and for the set-beats-clear collision. They also cover software setting a flag and software clears of specific bits. Finally, they show writes to mirrors, to the hole and to select 3 leaving no trace.

// File: rtl/pifr_pkg.sv
package pifr_pkg;

  localparam int REG_W    = 8;
  localparam int NUM_REGS = 3;
  localparam int FLAT_W   = REG_W * NUM_REGS;
  localparam int NUM_CCP  = 5;
  localparam int NUM_UART = 2;

  typedef enum logic [1:0] {
    BK_STICKY = 2'd0,
    BK_RX     = 2'd1,
    BK_TX     = 2'd2,
    BK_NONE   = 2'd3
  } bit_kind_e;

  // Behaviour class of each flat flag position.
  function automatic bit_kind_e kind_of(input int idx);
    case (idx)
      5, 21:   return BK_RX;
      4, 20:   return BK_TX;
      13:      return BK_NONE;
      default: return BK_STICKY;
    endcase
  endfunction

  // Flat position of each capture/compare channel flag.
  function automatic int ccp_pos(input int ch);
    case (ch)
      0:       return 2;
      1:       return 8;
      2:       return 16;
      3:       return 17;
      default: return 18;
    endcase
  endfunction

  // UART channel that drives a mirror position.
  function automatic int uart_of(input int idx);
    return (idx >= 2 * REG_W) ? 1 : 0;
  endfunction

  function automatic logic [FLAT_W-1:0] sticky_mask();
    logic [FLAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < FLAT_W; i++) m[i] = (kind_of(i) == BK_STICKY);
    return m;
  endfunction

  function automatic logic [FLAT_W-1:0] ccp_mask();
    logic [FLAT_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CCP; c++) m[ccp_pos(c)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/pifr_flag_cell.sv
module pifr_flag_cell
  import pifr_pkg::*;
#(
  parameter bit_kind_e KIND = BK_STICKY
) (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic lvl,
  output logic q
);

  generate
    if (KIND == BK_STICKY) begin : g_sticky
      logic unused_cell;
      assign unused_cell = lvl;
      always_ff @(posedge clk) begin
        if (rst)          q <= 1'b0;
        else if (set_evt) q <= 1'b1;     // event beats a clear
        else if (wr_en)   q <= wr_bit;
      end
    end else if (KIND == BK_RX || KIND == BK_TX) begin : g_mirror
      logic unused_cell;
      assign unused_cell = set_evt ^ wr_en ^ wr_bit;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= lvl;
      end
    end else begin : g_hole
      logic unused_cell;
      assign unused_cell = ^{clk, rst, set_evt, wr_en, wr_bit, lvl};
      assign q = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pifr_event_gate.sv
module pifr_event_gate
  import pifr_pkg::*;
#(
  parameter int FW = FLAT_W,
  parameter int NC = NUM_CCP
) (
  input  logic [FW-1:0] evt,
  input  logic [NC-1:0] pwm,
  output logic [FW-1:0] gated
);

  always_comb begin
    gated = evt;
    for (int c = 0; c < NC; c++) begin
      if (pwm[c]) gated[ccp_pos(c)] = 1'b0;
    end
  end

endmodule

// File: rtl/pifr_read_mux.sv
module pifr_read_mux #(
  parameter int RW = 8,
  parameter int NR = 3,
  parameter int AW = 2,
  localparam int FW = RW * NR
) (
  input  logic [FW-1:0] flags,
  input  logic [AW-1:0] addr,
  output logic [RW-1:0] rdata
);

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NR; r++) begin
      if (addr == AW'(r)) rdata = flags[r*RW +: RW];
    end
  end

endmodule

// File: rtl/pifr_bank.sv
module pifr_bank
  import pifr_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int NR = NUM_REGS,
  parameter int AW = 2,
  parameter int NC = NUM_CCP,
  parameter int NU = NUM_UART,
  localparam int FW = RW * NR
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] evt_pulse,
  input  logic [NC-1:0] ccp_pwm,
  input  logic [NU-1:0] rx_full,
  input  logic [NU-1:0] tx_empty,
  input  logic [AW-1:0] sw_addr,
  input  logic          sw_we,
  input  logic [RW-1:0] sw_wdata,
  output logic [RW-1:0] sw_rdata,
  output logic [FW-1:0] flag_vec
);

  logic [FW-1:0] evt_gated;
  logic [FW-1:0] mirror_lvl;
  logic [NR-1:0] reg_wr;

  pifr_event_gate #(.FW(FW), .NC(NC)) u_gate (
    .evt   (evt_pulse),
    .pwm   (ccp_pwm),
    .gated (evt_gated)
  );

  genvar r, b;
  generate
    for (r = 0; r < NR; r++) begin : g_reg
      assign reg_wr[r] = sw_we && (sw_addr == AW'(r));
      for (b = 0; b < RW; b++) begin : g_bit
        localparam int IDX = r * RW + b;
        if (kind_of(IDX) == BK_RX) begin : g_rx
          assign mirror_lvl[IDX] = rx_full[uart_of(IDX)];
        end else if (kind_of(IDX) == BK_TX) begin : g_tx
          assign mirror_lvl[IDX] = tx_empty[uart_of(IDX)];
        end else begin : g_nolvl
          assign mirror_lvl[IDX] = 1'b0;
        end
        pifr_flag_cell #(.KIND(kind_of(IDX))) u_cell (
          .clk     (clk),
          .rst     (rst),
          .set_evt (evt_gated[IDX]),
          .wr_en   (reg_wr[r]),
          .wr_bit  (sw_wdata[b]),
          .lvl     (mirror_lvl[IDX]),
          .q       (flag_vec[IDX])
        );
      end
    end
  endgenerate

  pifr_read_mux #(.RW(RW), .NR(NR), .AW(AW)) u_rmux (
    .flags (flag_vec),
    .addr  (sw_addr),
    .rdata (sw_rdata)
  );

endmodule

// File: rtl/pifr_bank_chk.sv
module pifr_bank_chk
  import pifr_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic [FLAT_W-1:0]   evt_pulse,
  input logic [NUM_CCP-1:0]  ccp_pwm,
  input logic [NUM_UART-1:0] rx_full,
  input logic [NUM_UART-1:0] tx_empty,
  input logic [1:0]          sw_addr,
  input logic                sw_we,
  input logic [REG_W-1:0]    sw_wdata,
  input logic [REG_W-1:0]    sw_rdata,
  input logic [FLAT_W-1:0]   flag_vec
);

  localparam logic [FLAT_W-1:0] STK   = sticky_mask();
  localparam logic [FLAT_W-1:0] PLAIN = sticky_mask() & ~ccp_mask();

  logic [FLAT_W-1:0] wr_mask;
  logic              unused_chk;
  assign unused_chk = ^sw_wdata;

  always_comb begin
    wr_mask = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (sw_we && sw_addr == 2'(r)) wr_mask[r*REG_W +: REG_W] = '1;
  end

  // R2: an ungated strobe on a sticky bit is visible after one edge
  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((flag_vec & $past(evt_pulse & PLAIN)) == $past(evt_pulse & PLAIN)));

  // R3: set sticky bits stay set when their register is not written
  a_r3_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((flag_vec & $past(flag_vec & ~wr_mask & STK)) == $past(flag_vec & ~wr_mask & STK)));

  // R6: receive mirrors follow their level one cycle late
  a_r6_rx_mirror: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (flag_vec[5] == $past(rx_full[0]) && flag_vec[21] == $past(rx_full[1])));

  // R7: transmit mirrors follow their level one cycle late
  a_r7_tx_mirror: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (flag_vec[4] == $past(tx_empty[0]) && flag_vec[20] == $past(tx_empty[1])));

  // R8: the unimplemented position is always zero
  a_r8_hole_zero: assert property (@(posedge clk) disable iff (rst)
    !flag_vec[13] && !(sw_addr == 2'd1 && sw_rdata[5]));

  // R9: a PWM-mode channel flag cannot rise without a software write
  generate
    for (genvar c = 0; c < NUM_CCP; c++) begin : g_pwm
      a_r9_pwm_blocks: assert property (@(posedge clk) disable iff (rst)
        $past(ccp_pwm[c] && !flag_vec[ccp_pos(c)] && !wr_mask[ccp_pos(c)] && !rst)
          |-> !flag_vec[ccp_pos(c)]);
    end
  endgenerate

  // R10: read port agrees with the flag vector; select 3 reads zero
  a_r10_read_port: assert property (@(posedge clk) disable iff (rst)
    (sw_addr != 2'd3) |-> (sw_rdata == flag_vec[sw_addr*REG_W +: REG_W]));

  a_r10_addr3_zero: assert property (@(posedge clk) disable iff (rst)
    (sw_addr == 2'd3) |-> (sw_rdata == '0));

endmodule

bind pifr_bank pifr_bank_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_pulse (evt_pulse),
  .ccp_pwm   (ccp_pwm),
  .rx_full   (rx_full),
  .tx_empty  (tx_empty),
  .sw_addr   (sw_addr),
  .sw_we     (sw_we),
  .sw_wdata  (sw_wdata),
  .sw_rdata  (sw_rdata),
  .flag_vec  (flag_vec)
);

// File: tb/pifr_bank_tb.sv
module pifr_bank_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [23:0] evt_pulse;
  logic [4:0]  ccp_pwm;
  logic [1:0]  rx_full;
  logic [1:0]  tx_empty;
  logic [1:0]  sw_addr;
  logic        sw_we;
  logic [7:0]  sw_wdata;
  logic [7:0]  sw_rdata;
  logic [23:0] flag_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  pifr_bank u_dut (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .ccp_pwm(ccp_pwm),
    .rx_full(rx_full), .tx_empty(tx_empty), .sw_addr(sw_addr),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .flag_vec(flag_vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [23:0] m);
    evt_pulse = m; tick(); evt_pulse = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    sw_addr = a; sw_wdata = d; sw_we = 1'b1; tick(); sw_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    sw_addr = a; #1; d = sw_rdata;
  endtask

  task automatic clear_all();
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst = 1'b1; evt_pulse = '1; ccp_pwm = '0; rx_full = 2'b11; tx_empty = 2'b11;
    sw_addr = '0; sw_we = 1'b0; sw_wdata = '0;
    repeat (3) tick();
    chk("R1 flags in reset", flag_vec, 24'h0);
    evt_pulse = '0; rx_full = '0; tx_empty = '0;
    tick(); rst = 1'b0; tick();
    chk("R1 flags after reset", flag_vec, 24'h0);
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), d);
      chk("R1 read after reset", d, 8'h00);
    end
  endtask

  task automatic t_event_hold_clear();
    logic [7:0] d;
    pulse(24'h808081);
    chk("R2 events set flags", flag_vec, 24'h808081);
    rd(2'd0, d);
    chk("R10 read reg0", d, 8'h81);
    repeat (3) tick();
    chk("R3 flags hold", flag_vec, 24'h808081);
    wr(2'd0, 8'h00);
    chk("R3 reg0 cleared", flag_vec, 24'h808000);
    clear_all();
    chk("R3 all cleared", flag_vec, 24'h0);
  endtask

  task automatic t_collide();
    wr(2'd0, 8'h03);
    chk("R5 sw set reg0", flag_vec, 24'h000003);
    evt_pulse = 24'h000002; sw_addr = 2'd0; sw_wdata = 8'h00; sw_we = 1'b1;
    tick(); evt_pulse = '0; sw_we = 1'b0;
    chk("R4 set beats clear", flag_vec, 24'h000002);
    clear_all();
  endtask

  task automatic t_sw_set();
    wr(2'd2, 8'hFF);
    chk("R5 R6 R7 sw set reg2", flag_vec, 24'hCF0000);
    wr(2'd0, 8'hFF);
    chk("R5 R6 R7 sw set reg0", flag_vec, 24'hCF00CF);
    clear_all();
    chk("R3 sw clear", flag_vec, 24'h0);
  endtask

  task automatic t_mirror();
    rx_full = 2'b01; tx_empty = 2'b10; tick();
    chk("R6 R7 mirror pattern a", flag_vec, 24'h100020);
    wr(2'd0, 8'h00); wr(2'd2, 8'h00);
    chk("R6 R7 mirror ignores writes", flag_vec, 24'h100020);
    rx_full = 2'b10; tx_empty = 2'b01; tick();
    chk("R6 R7 mirror pattern b", flag_vec, 24'h200010);
    rx_full = 2'b00; tx_empty = 2'b00; tick();
    chk("R6 R7 mirror drop", flag_vec, 24'h0);
  endtask

  task automatic t_hole();
    logic [7:0] d;
    wr(2'd1, 8'hFF);
    rd(2'd1, d);
    chk("R8 hole ignores write", d, 8'hDF);
    wr(2'd1, 8'h00);
    pulse(24'h002000);
    chk("R8 hole ignores event", flag_vec, 24'h0);
  endtask

  task automatic t_pwm();
    ccp_pwm = 5'b11111;
    pulse(24'h070104);
    chk("R9 all channels in pwm", flag_vec, 24'h0);
    ccp_pwm = 5'b00100;
    pulse(24'h070104);
    chk("R9 channel 2 in pwm", flag_vec, 24'h060104);
    ccp_pwm = 5'b00000;
    clear_all();
  endtask

  task automatic t_addr3();
    logic [7:0] d;
    wr(2'd3, 8'hFF);
    chk("R10 select 3 write ignored", flag_vec, 24'h0);
    rd(2'd3, d);
    chk("R10 select 3 reads zero", d, 8'h00);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_event_hold_clear();
    t_collide();
    t_sw_set();
    t_mirror();
    t_hole();
    t_pwm();
    t_addr3();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule